// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral on a small register bus. Once software enables it, a counter advances on one of two tick sources. If software does not restart the counter before it reaches two to the power of the programmed period, the block raises a one-cycle reset request toward the system. The control word is guarded against stray stores: it changes only through a two-write unlock, where the first write carries key 0x55 and the second carries key 0xAA with the same payload.

A fuse-style input picks whether the watchdog comes out of reset already running. A sticky flag records that a watchdog timeout happened. Only a power-on reset clears that flag. During a debug halt the counter stops, unless both a global run-in-debug enable and the per-peripheral debug enable are asserted. The two tick inputs stand in for an internal RC clock and a crystal clock. The block itself runs on a single clock.

Top module: `keyed_watchdog`

## Requirements
- R1: Register map, one word per address:
  - Address 0 is the control word. Bits [31:24] are the key and read as 0. Bit 0 is the enable. Bit 1 selects the tick (0 = rcTick, 1 = xtalTick). Bits [5:2] hold the period.
  - Address 1 is the restart register. It is write-only and reads 0.
  - Address 2 is status. Bit 0 is the timeout cause flag.
  - Address 3 reads the current count.
  - A write at address 0 with key 0x55, followed by a write at address 0 with key 0xAA, loads the control word. Non-bus cycles may come between the two writes.
- R2: If bits [23:0] of the 0xAA write differ from those of the 0x55 write, the control word keeps its old value.
- R3: The control word keeps its old value in three cases: a 0xAA write with no preceding 0x55 write, a second write carrying any other key, or any write to another address between the two keyed writes.
- R4: While enabled, the count advances by one on each cycle in which the selected tick is high. The advance that would make the count equal 2^period instead returns it to 0. resetReq is high for the one cycle that follows that advance.
- R5: A write at address 1 with bits [31:24] = 0xC3 sets the count to 0. A write there with any other key leaves the count untouched.
- R6: With select 0 only rcTick advances the count. With select 1 only xtalTick advances it.
- R7: While dbgHalt is high the count holds its value, unless dbgRunGlobal and dbgPerEn are both high.
- R8: A timeout sets causeWdog (also status bit 0) on the cycle after resetReq. It stays set through rstN and is cleared only by porN.
- R9: On rstN or porN, the enable takes the value of autoEn and the period becomes 4. The select returns to 0 after a porN, or after an rstN with no timeout since the previous reset. After an rstN that follows a timeout, the select keeps its value.
- R10: Loading the control word restarts the count from 0. While disabled, the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, synchronous |
| rstN | input | 1 | System reset, active low, synchronous |
| autoEn | input | 1 | Fuse-style enable value taken at reset |
| wrEn | input | 1 | Bus write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, combinational on addr |
| rcTick | input | 1 | Advance enable from the internal RC source |
| xtalTick | input | 1 | Advance enable from the crystal source |
| dbgHalt | input | 1 | CPU is halted in debug |
| dbgRunGlobal | input | 1 | Global run-in-debug enable |
| dbgPerEn | input | 1 | Per-peripheral debug run enable |
| resetReq | output | 1 | One-cycle reset request on timeout |
| causeWdog | output | 1 | Sticky watchdog-reset cause flag |

## Verification
A wrong unlock state shows up at address 0 on the first read after the second keyed write: the control word either moves when it should not, or stays put when it should move. A wrong count shows up at address 3 on the next bus read. It also moves the resetReq edge: sweeping the period shifts that edge by an exactly predictable number of cycles. A lost cause flag or a wrong select after reset is seen at rdata on the first read after rstN is released.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Word addresses of the register bus
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_KICK   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] KEY_KICK   = 8'hC3;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;  // zero the count this cycle
    logic run;      // watchdog enabled
    logic useXtal;  // tick source select
  } wdog_cmd_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PER_W      = 4,
  parameter int DEF_PERIOD = 4,
  localparam int CTRL_W    = 2 + PER_W
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              autoEn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              expire,
  output wdog_cmd_t         cmd,
  output logic [PER_W-1:0]  period,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              cause
);
  logic        enReg;
  logic        selReg;
  logic        armed;
  logic [23:0] pending;
  logic        tripped;   // a timeout occurred since the last reset
  logic        inReset;
  logic        commit;
  logic        kick;
  logic [7:0]  key;

  assign key    = wdata[31:24];
  assign commit = wrEn && (addr == ADDR_CTRL) && (key == KEY_SECOND)
                  && armed && (wdata[23:0] == pending);
  assign kick   = wrEn && (addr == ADDR_KICK) && (key == KEY_KICK);

  always_ff @(posedge clk) begin
    if (!porN) begin
      enReg   <= autoEn;
      selReg  <= 1'b0;
      period  <= PER_W'(DEF_PERIOD);
      armed   <= 1'b0;
      pending <= '0;
      cause   <= 1'b0;
      tripped <= 1'b0;
      inReset <= 1'b1;
    end else if (!rstN) begin
      enReg   <= autoEn;
      period  <= PER_W'(DEF_PERIOD);
      armed   <= 1'b0;
      inReset <= 1'b1;
      if (!tripped && !expire) selReg <= 1'b0;
      if (expire) begin
        cause   <= 1'b1;
        tripped <= 1'b1;
      end
    end else begin
      inReset <= 1'b0;
      if (inReset) tripped <= 1'b0;
      if (expire) begin
        cause   <= 1'b1;
        tripped <= 1'b1;
      end
      if (wrEn) begin
        armed <= 1'b0;
        if (addr == ADDR_CTRL && key == KEY_FIRST) begin
          armed   <= 1'b1;
          pending <= wdata[23:0];
        end
        if (commit) begin
          enReg  <= wdata[0];
          selReg <= wdata[1];
          period <= wdata[2 +: PER_W];
        end
      end
    end
  end

  assign cmd.restart = rstN && (commit || kick);
  assign cmd.run     = enReg;
  assign cmd.useXtal = selReg;
  assign ctrlWord    = {period, selReg, enReg};
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PER_W = 4,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdog_cmd_t        cmd,
  input  logic [PER_W-1:0] period,
  input  logic             rcTick,
  input  logic             xtalTick,
  input  logic             dbgHalt,
  input  logic             dbgRunGlobal,
  input  logic             dbgPerEn,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic             tick;
  logic             frozen;
  logic             advance;
  logic [LIM_W-1:0] lastVal;

  assign tick    = cmd.useXtal ? xtalTick : rcTick;
  assign frozen  = dbgHalt && !(dbgRunGlobal && dbgPerEn);
  assign advance = cmd.run && tick && !frozen;
  assign lastVal = (LIM_W'(1) << period) - LIM_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (cmd.restart || !cmd.run) begin
        cnt <= '0;
      end else if (advance) begin
        if ({1'b0, cnt} == lastVal) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PER_W      = 4,
  parameter int DEF_PERIOD = 4
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic        autoEn,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rcTick,
  input  logic        xtalTick,
  input  logic        dbgHalt,
  input  logic        dbgRunGlobal,
  input  logic        dbgPerEn,
  output logic        resetReq,
  output logic        causeWdog
);
  localparam int CTRL_W = 2 + PER_W;

  wdog_cmd_t         cmd;
  logic [PER_W-1:0]  period;
  logic [CTRL_W-1:0] ctrlWord;
  logic [CNT_W-1:0]  cntVal;
  logic              expire;
  logic              anyRstN;

  assign anyRstN = porN && rstN;

  wdog_ctrl #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .autoEn(autoEn),
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .expire(expire),
    .cmd(cmd), .period(period), .ctrlWord(ctrlWord), .cause(causeWdog)
  );

  wdog_datapath #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(anyRstN), .cmd(cmd), .period(period),
    .rcTick(rcTick), .xtalTick(xtalTick), .dbgHalt(dbgHalt),
    .dbgRunGlobal(dbgRunGlobal), .dbgPerEn(dbgPerEn),
    .cnt(cntVal), .expire(expire)
  );

  assign resetReq = expire;

  always_comb begin
    unique case (addr)
      ADDR_CTRL:   rdata = 32'(ctrlWord);
      ADDR_KICK:   rdata = '0;
      ADDR_STATUS: rdata = {31'b0, causeWdog};
      default:     rdata = 32'(cntVal);
    endcase
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W  = 16,
  parameter int PER_W  = 4,
  localparam int CTRL_W = 2 + PER_W
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [31:0]       wdata,
  input logic              dbgHalt,
  input logic              dbgRunGlobal,
  input logic              dbgPerEn,
  input logic              resetReq,
  input logic              causeWdog,
  input logic [CNT_W-1:0]  cntVal,
  input logic [PER_W-1:0]  period,
  input logic [CTRL_W-1:0] ctrlWord
);
  assert_ctrl_locked_R1: assert property (@(posedge clk) disable iff (!porN || !rstN)
    !(wrEn && addr == 2'd0 && wdata[31:24] == 8'hAA) |=> $stable(ctrlWord));

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ({1'b0, cntVal} < ((CNT_W+1)'(1) << period)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (resetReq && period != '0) |=> !resetReq);

  assert_debug_hold_R7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!wrEn && dbgHalt && !(dbgRunGlobal && dbgPerEn)) |=> $stable(cntVal));

  assert_cause_set_R8: assert property (@(posedge clk) disable iff (!porN)
    resetReq |=> causeWdog);

  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!porN)
    causeWdog |=> causeWdog);
endmodule

bind keyed_watchdog wdog_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .porN(porN), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .dbgHalt(dbgHalt), .dbgRunGlobal(dbgRunGlobal), .dbgPerEn(dbgPerEn),
  .resetReq(resetReq), .causeWdog(causeWdog), .cntVal(cntVal),
  .period(period), .ctrlWord(ctrlWord)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0, autoEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rcTick = 1'b1, xtalTick = 1'b0;
  logic        dbgHalt = 1'b0, dbgRunGlobal = 1'b0, dbgPerEn = 1'b0;
  logic        resetReq, causeWdog;
  int          vectors = 0, miscompares = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .autoEn(autoEn),
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rcTick(rcTick), .xtalTick(xtalTick), .dbgHalt(dbgHalt),
    .dbgRunGlobal(dbgRunGlobal), .dbgPerEn(dbgPerEn),
    .resetReq(resetReq), .causeWdog(causeWdog)
  );

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] cfg(bit en, bit sel, int p);
    return 24'({p[3:0], sel, en});
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic unlock(logic [23:0] c);
    wr(2'd0, {8'h55, c});
    wr(2'd0, {8'hAA, c});
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulseRst();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog timer expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    // Reset state: disabled, select 0, period 4
    rd(2'd0, v); chk("R9 ctrl after por", v, 16);
    rd(2'd2, v); chk("R8 cause after por", v, 0);
    rd(2'd3, v); chk("R10 count idle", v, 0);
    chk("R4 no request at reset", resetReq, 0);

    // Bad sequences
    wr(2'd0, {8'hAA, cfg(1, 1, 7)});
    rd(2'd0, v); chk("R3 lone second key", v, 16);
    wr(2'd0, {8'h55, cfg(1, 1, 7)}); wr(2'd1, 32'h0); wr(2'd0, {8'hAA, cfg(1, 1, 7)});
    rd(2'd0, v); chk("R3 intervening write", v, 16);
    wr(2'd0, {8'h55, cfg(1, 1, 7)}); wr(2'd0, {8'h12, cfg(1, 1, 7)});
    rd(2'd0, v); chk("R3 wrong second key", v, 16);
    unlock(cfg(1, 1, 7)); rd(2'd0, v); chk("R1 valid unlock loads", v, 31);
    unlock(cfg(0, 0, 4));
    wr(2'd0, {8'h55, cfg(1, 0, 3)}); wr(2'd0, {8'hAA, cfg(1, 0, 2)});
    rd(2'd0, v); chk("R2 payload mismatch", v, 16);
    wr(2'd0, {8'h55, cfg(1, 0, 3)}); @(negedge clk); @(negedge clk);
    wr(2'd0, {8'hAA, cfg(1, 0, 3)});
    rd(2'd0, v); chk("R1 idle gap between keys", v, 13);

    // Timeout sweep over periods
    for (int p = 0; p <= 6; p++) begin
      unlock(cfg(1, 0, p));
      n = 0;
      while (n < 200) begin
        @(negedge clk); n++;
        if (resetReq) break;
      end
      chk($sformatf("R4 timeout cycles period %0d", p), n, 1 << p);
      if (p == 3) begin
        n = 0;
        while (n < 200) begin
          @(negedge clk); n++;
          if (resetReq) break;
        end
        chk("R4 wrap to second timeout", n, 8);
      end
    end
    @(negedge clk);
    rd(2'd2, v); chk("R8 cause set by timeout", v, 1);

    // Restart register
    unlock(cfg(1, 0, 6));
    rd(2'd3, v); chk("R10 commit restarts count", v, 0);
    repeat (10) @(negedge clk);
    rd(2'd3, v); chk("R4 count advances", v, 10);
    wr(2'd1, {8'hC3, 24'h0});
    rd(2'd3, v); chk("R5 valid restart", v, 0);
    repeat (3) @(negedge clk);
    wr(2'd1, {8'h11, 24'h0});
    rd(2'd3, v); chk("R5 wrong key ignored", v, 5);
    unlock(cfg(0, 0, 6)); repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R10 disabled holds zero", v, 0);

    // Tick source select
    unlock(cfg(1, 1, 6)); rcTick = 1'b1; xtalTick = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, v); chk("R6 select 1 ignores rcTick", v, 0);
    xtalTick = 1'b1; repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R6 select 1 follows xtalTick", v, 4);
    unlock(cfg(1, 0, 6)); rcTick = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R6 select 0 ignores xtalTick", v, 0);
    rcTick = 1'b1; xtalTick = 1'b0;

    // Debug freeze
    unlock(cfg(1, 0, 6));
    dbgHalt = 1'b1; repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R7 halt freezes", v, 0);
    dbgRunGlobal = 1'b1; repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R7 one enable still freezes", v, 0);
    dbgPerEn = 1'b1; repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R7 both enables run", v, 5);
    dbgHalt = 1'b0; dbgRunGlobal = 1'b0; dbgPerEn = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R7 runs after halt", v, 10);

    // Resets
    unlock(cfg(0, 1, 2));
    pulseRst();                 // clears the timeout history, keeps select
    unlock(cfg(0, 1, 2));
    autoEn = 1'b1;
    pulseRst();                 // no timeout since previous reset
    rd(2'd0, v); chk("R9 plain reset clears select", v, 17);
    rd(2'd2, v); chk("R8 cause survives rstN", v, 1);
    autoEn = 1'b0;
    unlock(cfg(1, 1, 1)); xtalTick = 1'b1;
    repeat (4) @(negedge clk);
    pulseRst();
    rd(2'd0, v); chk("R9 select kept after timeout reset", v, 18);
    @(negedge clk); porN = 1'b0; @(negedge clk); @(negedge clk); porN = 1'b1;
    rd(2'd2, v); chk("R8 por clears cause", v, 0);
    rd(2'd0, v); chk("R9 por clears select", v, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule